// File: doc/BRIEF.md
# Zero-Suppressing Four-to-One Channel Concentrator

This block is one level of a reduction tree that carries sparse trigger candidates toward a final decision stage. It takes four input channels, each offering at most one word per clock. A word whose value is zero means "nothing here", so the block discards it at the input. Each input channel has a zero filter of its own, so the filtering stage is exactly as wide as the layer that feeds it.

Non-zero words go into a small queue for their source. A round-robin merger drains the four queues into a single output stream, one word per clock. Each word leaves with a 2-bit source tag placed above its payload. Several levels can be cascaded, each level taking the previous level's output words as its payload. Each level cuts the channel count by four and widens the word by two tag bits, until few enough channels remain for the decision logic. Candidates are expected to be rare. The queues only absorb the occasional clock in which several sources fire together.

A queue that is full asserts a stall toward its source. A non-zero word offered against that stall is dropped, and an overflow bit reports the drop.

Top module: `zsc_concentrator`

## Requirements
- R1: An input word equal to zero is never forwarded. Over any stretch of input, the number of output words equals the number of accepted non-zero input words, and every output payload is non-zero.
- R2: `out_data` is `{tag, payload}`. The tag occupies the top 2 bits and holds the source index 0 to 3. The payload occupies the low `DATA_W` bits and is the input word unchanged.
- R3: Words from one source leave in the order in which that source delivered them.
- R4: Sources are served round-robin. After reset, source 0 has first turn. Each grant goes to the first non-empty queue after the last granted source, in ascending cyclic order 0, 1, 2, 3, 0.
- R5: `src_stall[i]` is high exactly while queue i holds `FIFO_DEPTH` words. A source that offers words only while its stall is low loses none of them.
- R6: A valid non-zero word offered while its stall is high is discarded. `src_overflow[i]` is high for one clock in the cycle after the drop, once per dropped word.
- R7: During and right after reset, `out_valid`, `src_stall` and `src_overflow` are all low.
- R8: On an idle block, a word offered before clock edge k is not visible after edge k. It is visible on the output after edge k+1. The output carries at most one word per clock and is low when all queues are empty.
- R9: Every accepted word appears on the output exactly once: none is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 4 | Per-source word valid |
| src_data | input | 4*DATA_W | Per-source words; source i in bits [i*DATA_W +: DATA_W] |
| src_stall | output | 4 | Per-source queue full; do not offer words |
| src_overflow | output | 4 | Per-source one-clock pulse after a dropped word |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W+2 | Source tag (top 2 bits) and payload |

## Verification
A table of single-cycle patterns is applied to an idle block. The patterns cover no candidates, one candidate alone on each of several sources, adjacent and non-adjacent pairs, three sources, and all four. Because they start from different round-robin positions, they separate a correct rotation from fixed priority, from a stuck pointer and from a grant that skips a requester, and they expose any zero word that leaks through. A continuous burst on all four sources, with the stall ignored, fills the queues. It checks that the stall appears and that each drop yields exactly one overflow pulse. A second burst honours the stall and must lose nothing. Throughout the run, a per-source scoreboard catches reordering, loss and duplication.

// File: rtl/zsc_pkg.sv
package zsc_pkg;
   localparam int NUM_SRC = 4;
   localparam int TAG_W   = $clog2(NUM_SRC);
endpackage

// File: rtl/zsc_zero_filter.sv
module zsc_zero_filter #(
   parameter int N = 4,
   parameter int W = 16
) (
   input  logic [N-1:0]   valid_i,
   input  logic [N*W-1:0] data_i,
   output logic [N-1:0]   keep_o
);
   for (genvar i = 0; i < N; i++) begin : g_ch
      assign keep_o[i] = valid_i[i] && (data_i[i*W +: W] != '0);
   end
endmodule

// File: rtl/zsc_fifo.sv
module zsc_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("zsc_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   count;
   logic          push, pop;

   assign push    = wr_en && !full;
   assign pop     = rd_en && !empty;
   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5: a full queue that is not read stays full
   a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);
   // R9: the merger never pops an empty queue
   a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/zsc_rr_arbiter.sv
module zsc_rr_arbiter #(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic [N-1:0]         grant,
   output logic [$clog2(N)-1:0] grant_idx,
   output logic                 grant_any
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] last;

   always_comb begin
      int c;
      grant_any = 1'b0;
      grant_idx = last;
      for (int k = 1; k <= N; k++) begin
         c = (int'(last) + k) % N;
         if (!grant_any && req[c]) begin
            grant_any = 1'b1;
            grant_idx = IW'(c);
         end
      end
      grant = grant_any ? (N'(1) << grant_idx) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         last <= IW'(N - 1);
      else if (grant_any) last <= grant_idx;
   end

   a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R4: with a second requester pending, the same source is not served twice running
   a_r4_rotates: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req) > 1) |=> (grant_idx != $past(grant_idx)));
endmodule

// File: rtl/zsc_concentrator.sv
module zsc_concentrator
   import zsc_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_valid,
   input  logic [NUM_SRC*DATA_W-1:0]   src_data,
   output logic [NUM_SRC-1:0]          src_stall,
   output logic [NUM_SRC-1:0]          src_overflow,
   output logic                        out_valid,
   output logic [DATA_W+TAG_W-1:0]     out_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("zsc_concentrator: DATA_W must be at least 1");
   end

   logic [NUM_SRC-1:0] keep, full, empty, grant;
   logic [DATA_W-1:0]  q_head [NUM_SRC];
   logic [TAG_W-1:0]   gidx;
   logic               gany;

   zsc_zero_filter #(.N(NUM_SRC), .W(DATA_W)) u_filter (
      .valid_i (src_valid),
      .data_i  (src_data),
      .keep_o  (keep)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      zsc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_q (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (keep[i]),
         .wr_data (src_data[i*DATA_W +: DATA_W]),
         .rd_en   (grant[i]),
         .rd_data (q_head[i]),
         .empty   (empty[i]),
         .full    (full[i])
      );

      // R6: a drop is only reported when the queue was full
      a_r6_overflow_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
         src_overflow[i] |-> $past(full[i]));
   end

   zsc_rr_arbiter #(.N(NUM_SRC)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (~empty),
      .grant     (grant),
      .grant_idx (gidx),
      .grant_any (gany)
   );

   assign src_stall = full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_overflow <= '0;
         out_valid    <= 1'b0;
         out_data     <= '0;
      end else begin
         src_overflow <= keep & full;
         out_valid    <= gany;
         if (gany) out_data <= {gidx, q_head[gidx]};
      end
   end

   // R1: a forwarded payload is never zero
   a_r1_nonzero_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[DATA_W-1:0] != '0));
   // R8: the output only carries a word that was queued a cycle earlier
   a_r8_out_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(empty != '1));
endmodule

// File: tb/zsc_concentrator_test.sv
`timescale 1ns/1ps
module zsc_concentrator_test;
   localparam int W = 16;
   localparam int D = 4;

   // each entry is {src3, src2, src1, src0}
   localparam logic [4*W-1:0] VEC [8] = '{
      64'h0000_0000_0000_0000,
      64'h0000_2001_0000_0000,
      64'h3002_0000_1002_0000,
      64'h3003_2003_1003_0003,
      64'h0000_0000_0000_0004,
      64'h3005_0000_0000_0005,
      64'h3006_2006_0000_0000,
      64'h0000_2007_1007_0007
   };

   logic           clk = 0;
   logic           rst_n = 0;
   logic [3:0]     src_valid = '0;
   logic [4*W-1:0] src_data = '0;
   logic [3:0]     src_stall, src_overflow;
   logic           out_valid;
   logic [W+1:0]   out_data;

   always #2.5 clk = ~clk;

   zsc_concentrator #(.DATA_W(W), .FIFO_DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_stall(src_stall), .src_overflow(src_overflow),
      .out_valid(out_valid), .out_data(out_data)
   );

   int checks = 0, fails = 0;
   logic [W-1:0] expq [4][64];
   int wr_i [4] = '{0, 0, 0, 0};
   int rd_i [4] = '{0, 0, 0, 0};
   int drop_cnt [4] = '{0, 0, 0, 0};
   int ovf_cnt  [4] = '{0, 0, 0, 0};
   logic [1:0] cap_tag [512];
   int ncap = 0;
   int last_tag = 3;
   bit done = 0;

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic drive(logic [3:0] v, logic [4*W-1:0] d);
      src_valid = v;
      src_data  = d;
      for (int i = 0; i < 4; i++) begin
         if (v[i] && d[i*W +: W] != '0) begin
            if (!src_stall[i]) begin
               expq[i][wr_i[i]] = d[i*W +: W];
               wr_i[i]++;
            end else begin
               drop_cnt[i]++;
            end
         end
      end
   endtask

   task automatic tick();
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (src_overflow[i]) ovf_cnt[i]++;
      if (out_valid) begin
         int t;
         t = int'(out_data[W+1:W]);
         cap_tag[ncap] = out_data[W+1:W];
         ncap++;
         last_tag = t;
         if (rd_i[t] >= wr_i[t]) begin
            check(0, "R9 unexpected word", int'(out_data[W-1:0]), 0);
         end else begin
            check(out_data[W-1:0] == expq[t][rd_i[t]], "R3/R2 payload order",
                  int'(out_data[W-1:0]), int'(expq[t][rd_i[t]]));
            rd_i[t]++;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int start, n0, exp_n, pos, sent_drops;
      bit stall_seen;
      logic [1:0] exp_order [4];
      logic [4*W-1:0] w;

      repeat (3) @(negedge clk);
      // R7 reset state
      check(out_valid == 0, "R7 out_valid in reset", out_valid, 0);
      check(src_stall == 0, "R7 stall in reset", src_stall, 0);
      rst_n = 1;
      tick();
      check(out_valid == 0 && src_stall == 0 && src_overflow == 0,
            "R7 after reset", {out_valid, src_stall, src_overflow}, 0);

      // R8 latency from an idle block
      drive(4'b0100, 64'h0000_0ABC_0000_0000);
      tick();
      check(out_valid == 0, "R8 not after first edge", out_valid, 0);
      drive(4'b0000, '0);
      tick();
      check(out_valid == 1, "R8 visible after second edge", out_valid, 1);
      check(out_data[W+1:W] == 2'd2, "R2 tag of source 2", out_data[W+1:W], 2);
      repeat (3) tick();

      // R1/R4 vector table
      for (int v = 0; v < 8; v++) begin
         start = last_tag;
         n0 = ncap;
         exp_n = 0;
         for (int j = 1; j <= 4; j++) begin
            int c;
            c = (start + j) % 4;
            if (VEC[v][c*W +: W] != '0) begin
               exp_order[exp_n] = 2'(c);
               exp_n++;
            end
         end
         drive(4'hF, VEC[v]);
         tick();
         drive(4'h0, '0);
         repeat (6) tick();
         check(ncap - n0 == exp_n, "R1 output count", ncap - n0, exp_n);
         for (int k = 0; k < exp_n && n0 + k < ncap; k++)
            check(cap_tag[n0 + k] == exp_order[k], "R4 round-robin order",
                  cap_tag[n0 + k], exp_order[k]);
      end

      // R5/R6 burst ignoring stall
      stall_seen = 0;
      for (int k = 0; k < 14; k++) begin
         for (int i = 0; i < 4; i++) w[i*W +: W] = 16'h4000 | 16'(i << 8) | 16'(k + 1);
         drive(4'hF, w);
         if (src_stall != 0) stall_seen = 1;
         tick();
      end
      drive(4'h0, '0);
      repeat (24) tick();
      check(stall_seen, "R5 stall raised under load", stall_seen, 1);
      sent_drops = drop_cnt[0] + drop_cnt[1] + drop_cnt[2] + drop_cnt[3];
      check(sent_drops > 0, "R6 drops occurred", sent_drops, 1);
      for (int i = 0; i < 4; i++)
         check(ovf_cnt[i] == drop_cnt[i], "R6 overflow pulses", ovf_cnt[i], drop_cnt[i]);

      // R5 burst honouring stall: no further drops
      for (int k = 0; k < 16; k++) begin
         for (int i = 0; i < 4; i++) w[i*W +: W] = 16'h5000 | 16'(i << 8) | 16'(k + 1);
         drive(~src_stall, w);
         tick();
      end
      drive(4'h0, '0);
      repeat (24) tick();
      pos = drop_cnt[0] + drop_cnt[1] + drop_cnt[2] + drop_cnt[3];
      check(pos == sent_drops, "R5 stall obeyed loses nothing", pos, sent_drops);
      check(out_valid == 0, "R8 idle when queues empty", out_valid, 0);

      // R9 every accepted word delivered once
      for (int i = 0; i < 4; i++)
         check(rd_i[i] == wr_i[i], "R9 delivered count", rd_i[i], wr_i[i]);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule